// File: doc/BRIEF.md
# Watchdog Countdown Timer with Masked Interrupt

This block is a 32-bit countdown timer that software reaches over a small register bus. The count is held as two 16-bit halves. It decrements once per timer tick. The tick is produced by an internal prescaler that divides the system clock by the parameter `DIV`, so that the tick rate is 5 MHz in the target system.

Two command bits in a control register start and stop the timer, and each one cancels the other. When the count passes below zero, it reloads to all ones and raises a completion flag in a status register. That flag, together with any other event bits applied through the `ev_set` input, is ANDed with a mask register and ORed into a single interrupt line. Software clears status bits by writing ones to them.

Register addresses on `bus_addr` are: 0 control, 1 count low half, 2 count high half, 3 status, 4 mask. Any other address reads as zero and ignores writes.

Top module: `wdog_countdown`

## Requirements
- R1: After reset the timer is stopped, so the control register reads 0x0002. Both count halves, the status register and the mask register read 0, and `irq` is low.
- R2: Writing the control register with bit 0 set and bit 1 clear starts the timer, and the control register then reads 0x0001. While the timer runs, the 32-bit count {high, low} falls by exactly one on each tick, and a borrow from the low half propagates into the high half.
- R3: Writing the control register with bit 1 set stops the timer and freezes the count; the control register then reads 0x0002. Bit 1 takes precedence when bits 0 and 1 are written together. While the timer is stopped, the count changes only through register writes.
- R4: A tick that arrives when the count is 0 reloads both halves to 0xFFFF and sets status bit 0.
- R5: Reading address 1 or 2 returns the live value of the count, including while the timer is running.
- R6: A write to either count half replaces that half, takes precedence over a tick in the same cycle, and restarts the prescaler. The next tick therefore comes `DIV` cycles after the write and decrements from the new combined value.
- R7: Writing the status register clears each bit whose written bit is 1 and leaves the other bits unchanged. A bit that `ev_set` or an underflow sets in the same cycle stays set.
- R8: `irq` is high exactly when the status register and the mask register share at least one set bit.
- R9: Bit 15 of the mask register cannot be written and always reads 0.
- R10: While the timer runs, a tick occurs every `DIV` clock cycles, counted from the start command. After k cycles the count equals its starting value minus floor(k/DIV).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, a combinational function of `bus_addr` |
| ev_set | input | 16 | Set pulses for status bits from other event sources |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that each bus write lasts a single cycle. They also assume that the only writes that change the count are writes to addresses 1 and 2, so any cycle without a write lets the count follow the tick alone. The assertions do not constrain `ev_set` except in the clear check, which holds only when the same bit is not being set in that cycle. The stimulus drives every input on the falling edge, raises `bus_wr` for one edge per access, and applies `ev_set` pulses one edge wide. It sweeps starting counts that include the borrow case and a count of zero with `DIV` set to 3, so every prescaler phase is covered.

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic [15:0] ev_set,
  output logic        irq
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CLO  = 3'd1;
  localparam logic [2:0] A_CHI  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;

  logic        run_q;
  logic [31:0] cnt_q;
  logic [15:0] stat_q;
  logic [15:0] mask_q;
  logic        tick;

  wire wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  wire wr_lo     = bus_wr && bus_addr == A_CLO;
  wire wr_hi     = bus_wr && bus_addr == A_CHI;
  wire wr_stat   = bus_wr && bus_addr == A_STAT;
  wire wr_mask   = bus_wr && bus_addr == A_MASK;
  wire stop_cmd  = wr_ctrl && bus_wdata[1];
  wire start_cmd = wr_ctrl && bus_wdata[0] && !bus_wdata[1];
  wire dec_en    = tick && !stop_cmd && !wr_lo && !wr_hi;
  wire uflow     = dec_en && cnt_q == 32'd0;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run_q;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pre_q <= '0;
        else if (!run_q || start_cmd || wr_lo || wr_hi || pre_q == PW'(DIV - 1))
          pre_q <= '0;
        else
          pre_q <= pre_q + 1'b1;
      end
      assign tick = run_q && pre_q == PW'(DIV - 1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= 1'b0;
    else if (stop_cmd)
      run_q <= 1'b0;
    else if (start_cmd)
      run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[15:0]  <= bus_wdata;
      if (wr_hi) cnt_q[31:16] <= bus_wdata;
    end else if (uflow) begin
      cnt_q <= '1;
    end else if (dec_en) begin
      cnt_q <= cnt_q - 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~(wr_stat ? bus_wdata : 16'h0)) | ev_set | {15'h0, uflow};
      if (wr_mask) mask_q <= {1'b0, bus_wdata[14:0]};
    end
  end

  assign irq = |(stat_q & mask_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {14'h0, !run_q, run_q};
      A_CLO:   bus_rdata = cnt_q[15:0];
      A_CHI:   bus_rdata = cnt_q[31:16];
      A_STAT:  bus_rdata = stat_q;
      A_MASK:  bus_rdata = mask_q;
      default: bus_rdata = 16'h0;
    endcase
  end
endmodule

module wdog_countdown_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] ev_set,
  input logic        run_q,
  input logic        tick,
  input logic [31:0] cnt_q,
  input logic [15:0] stat_q,
  input logic [15:0] mask_q,
  input logic        irq
);
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !bus_wr && cnt_q != 32'd0) |=> cnt_q == $past(cnt_q) - 32'd1);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !bus_wr) |=> $stable(cnt_q));

  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && bus_wdata[1]) |=> !run_q);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !bus_wr && cnt_q == 32'd0) |=> (cnt_q == 32'hFFFF_FFFF && stat_q[0]));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && bus_wdata[5] && !ev_set[5]) |=> !stat_q[5]);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 16'h0) |-> !irq);

  p_mask_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[15]);
endmodule

bind wdog_countdown wdog_countdown_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .ev_set(ev_set), .run_q(run_q), .tick(tick),
  .cnt_q(cnt_q), .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/test_wdog_countdown.sv
module test_wdog_countdown;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [15:0] ev_set = 16'h0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [15:0] v;
  logic [31:0] c;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_countdown #(.DIV(DIV)) i_wdog_countdown (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_set(ev_set), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdcnt(output logic [31:0] d);
    logic [15:0] h, l;
    rd(3'd2, h);
    rd(3'd1, l);
    d = {h, l};
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl", v, 32'h2);
    rdcnt(c);    chk("R1 count", c, 32'h0);
    rd(3'd3, v); chk("R1 status", v, 32'h0);
    rd(3'd4, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", irq, 32'h0);

    foreach (ctab[i]) begin end

    // Sweep of starting counts, including a borrow into the high half
    for (int s = 0; s < 4; s++) begin
      logic [31:0] init;
      init = (s == 0) ? 32'd100 : (s == 1) ? 32'h0001_0000 : (s == 2) ? 32'h0002_0001 : 32'd7;
      wr(3'd0, 16'h0002);
      wr(3'd1, init[15:0]);
      wr(3'd2, init[31:16]);
      repeat (5) @(negedge clk);
      rdcnt(c); chk("R3 frozen while stopped", c, init);
      wr(3'd0, 16'h0001);
      rd(3'd0, v); chk("R2 ctrl running", v, 32'h1);
      for (int k = 0; k < 10; k++) begin
        rdcnt(c);
        chk("R2 R5 R10 live count", c, init - 32'(k / DIV));
        @(negedge clk);
      end
    end

    // Stop freezes
    wr(3'd0, 16'h0002);
    rd(3'd0, v); chk("R3 ctrl stopped", v, 32'h2);
    rdcnt(c);
    repeat (12) @(negedge clk);
    begin
      logic [31:0] c2;
      rdcnt(c2); chk("R3 held after stop", c2, c);
    end

    // Underflow with interrupt
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h0001);
    repeat (8) @(negedge clk);
    rdcnt(c);    chk("R4 count at zero", c, 32'h0);
    rd(3'd3, v); chk("R4 no flag before underflow", v, 32'h0);
    chk("R8 irq low before underflow", irq, 32'h0);
    @(negedge clk);
    rdcnt(c);    chk("R4 reload all ones", c, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R4 completion flag", v, 32'h1);
    chk("R8 irq high", irq, 32'h1);
    repeat (3) @(negedge clk);
    rdcnt(c);    chk("R4 continues after reload", c, 32'hFFFF_FFFE);

    // Count write while running
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'd10);
    for (int k = 0; k < 7; k++) begin
      rdcnt(c);
      chk("R6 restart from written value", c, 32'd10 - 32'(k / DIV));
      @(negedge clk);
    end
    wr(3'd0, 16'h0003);
    rd(3'd0, v); chk("R3 stop wins over start", v, 32'h2);

    // Status clear and event sets
    wr(3'd3, 16'h0001);
    rd(3'd3, v); chk("R7 clear flag", v, 32'h0);
    chk("R8 irq after clear", irq, 32'h0);
    @(negedge clk); ev_set = 16'h0020;
    @(negedge clk); ev_set = 16'h0000;
    rd(3'd3, v); chk("R7 event sets bit 5", v, 32'h20);
    chk("R8 unmasked bit gives no irq", irq, 32'h0);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); chk("R9 mask top bit reads 0", v, 32'h7FFF);
    chk("R8 irq with mask", irq, 32'h1);
    wr(3'd3, 16'h0001);
    rd(3'd3, v); chk("R7 clearing unset bit leaves others", v, 32'h20);
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 16'h0020; bus_wr = 1'b1; ev_set = 16'h0020;
    @(negedge clk);
    bus_wr = 1'b0; ev_set = 16'h0000;
    rd(3'd3, v); chk("R7 set wins over clear", v, 32'h20);
    wr(3'd3, 16'h0020);
    rd(3'd3, v); chk("R7 clear bit 5", v, 32'h0);
    chk("R8 irq low when status empty", irq, 32'h0);

    finish_run();
  end

  logic [0:0] ctab [1];
endmodule